// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This block moves a processor core from one operating point to another. An operating point is a voltage code paired with a clock ratio. A request supplies the target point. The sequencer compares it with the point in force and then changes the voltage-ID output and the PLL ratio output in the order that keeps the core safe. When the ratio goes up, the voltage rises first. When the ratio goes down, the ratio drops first. The voltage code always moves one LSB at a time, with a programmable dwell between steps.

While the PLL relocks, the core is stalled and a bus-block output holds snoops off. The window ends when the PLL lock input comes back, or when a watchdog runs out. A request that arrives during a transition is held until the transition finishes, and only the newest held request is kept. A request for the point already in force finishes at once, without a stall. The voltage-ID and ratio outputs are the registers that hold the current point.

Top module: `vf_sequencer`

## Requirements
- R1: While reset is low at a clock edge, the block loads `vid_out` = DEF_VCODE (20) and `ratio_out` = DEF_RATIO (8), and drives `busy`, `core_stall`, `bus_block`, `done` and `lock_err` low.
- R2: If the target ratio is above the current ratio, `vid_out` reaches the target code before `ratio_out` changes. `ratio_out` then moves to the target ratio in one step.
- R3: If the target ratio is below the current ratio, `ratio_out` moves to the target on the clock edge after the request is taken. `vid_out` changes only after the relock window has ended.
- R4: Each change of `vid_out` is exactly +1 or -1.
- R5: In a stepping phase, each voltage step comes `dwell` + 1 cycles after the previous step, or after the start of the phase.
- R6: A request that arrives while `busy` is high does not change the transition in progress. It starts only after that transition completes.
- R7: Only the latest pending request is kept. Any earlier pending target is discarded without being applied.
- R8: `core_stall` is high exactly during the relock window. The window ends on the first cycle in which `pll_locked` is seen high after it has been seen low in the window. The window never lasts more than LOCK_MAX cycles (default 2500).
- R9: `bus_block` is high in exactly the same cycles as `core_stall`.
- R10: A request equal to the current point gives a `done` pulse two cycles after the request cycle. `busy` and `core_stall` stay low.
- R11: `done` is a one-cycle pulse, raised in the cycle after the final voltage code is seen in place. `busy` is high from the cycle after the request is taken until `done` rises.
- R12: If the lock does not come back within LOCK_MAX cycles, `lock_err` pulses for one cycle, the stall is released, and the voltage phase continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Target-point write strobe |
| req_vcode | input | VW | Requested voltage code |
| req_ratio | input | RW | Requested clock ratio |
| dwell | input | DW | Extra cycles between voltage steps |
| pll_locked | input | 1 | PLL lock indication |
| vid_out | output | VW | Current voltage-ID code |
| ratio_out | output | RW | Current PLL ratio |
| core_stall | output | 1 | Core held during relock |
| bus_block | output | 1 | Snoop hold-off during relock |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| lock_err | output | 1 | One-cycle relock timeout pulse |

## Verification
A wrong step or a wrong phase state shows at the ports within one cycle. It appears as a `vid_out` change of the wrong size, at the wrong time, or in the wrong order against `ratio_out`. A wrong dwell or watchdog count shows at the first step or the first relock that follows it: a step is one cycle early or late, or the stall is too long. A corrupted pending register shows only when the held request is started, as a wrong final point after the current transition.

// File: rtl/vfs_pkg.sv
// Shared types for the operating-point transition sequencer.
package vfs_pkg;
    // Sequencer phases, in the order a rising-ratio transition visits them.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VPRE   = 2'd1,
        ST_RELOCK = 2'd2,
        ST_VPOST  = 2'd3
    } vfs_state_e;
endpackage

// File: rtl/vfs_pending.sv
// Held-request register: captures every request write, and keeps only the
// newest one until the sequencer takes it.
// Assumes take is asserted only while pend_valid is high.
module vfs_pending #(
    parameter int VW = 6,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vcode,
    input  logic [RW-1:0] req_ratio,
    input  logic          take,
    output logic          pend_valid,
    output logic [VW-1:0] pend_vcode,
    output logic [RW-1:0] pend_ratio
);
    // Flag: set by a write, cleared by take unless a write arrives in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_valid <= 1'b0;
        else        pend_valid <= req_valid | (pend_valid & ~take);
    end

    // Data: each write overwrites whatever target is still pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vcode <= '0;
            pend_ratio <= '0;
        end else if (req_valid) begin
            pend_vcode <= req_vcode;
            pend_ratio <= req_ratio;
        end
    end

    AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_valid); // R6
endmodule

// File: rtl/vfs_vstep.sv
// Voltage stepper: while enabled, moves the voltage code one LSB toward the
// target every dwell+1 cycles. It issues step pulses; the owner of the code
// register applies them. Assumes dwell is held steady during a phase.
module vfs_vstep #(
    parameter int VW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [VW-1:0] cur_vcode,
    input  logic [VW-1:0] tgt_vcode,
    input  logic [DW-1:0] dwell,
    output logic          at_tgt,
    output logic          step_up,
    output logic          step_dn
);
    logic [DW-1:0] dcnt;
    logic          fire;

    // Step decision for the current cycle.
    always_comb begin
        at_tgt  = (cur_vcode == tgt_vcode);
        fire    = en && !at_tgt && (dcnt == dwell);
        step_up = fire && (tgt_vcode > cur_vcode);
        step_dn = fire && (tgt_vcode < cur_vcode);
    end

    // Dwell counter: runs only while stepping and restarts after each step.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dcnt <= '0;
        else if (!en || at_tgt || fire) dcnt <= '0;
        else                            dcnt <= dcnt + DW'(1);
    end

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn)); // R4
    AST_IDLE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> dcnt == '0); // R5
endmodule

// File: rtl/vfs_relock.sv
// Relock monitor: while enabled, it waits for the PLL lock input to be seen
// low and then high. A watchdog ends the wait after LOCK_MAX cycles.
// Assumes the PLL drops its lock within the window after a ratio change.
module vfs_relock #(
    parameter int LOCK_MAX = 2500,
    localparam int WW = $clog2(LOCK_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pll_locked,
    output logic lock_ok,
    output logic timeout
);
    logic [WW-1:0] wcnt;
    logic          seen_low;

    // Exit conditions for the current relock cycle.
    always_comb begin
        lock_ok = en && pll_locked && seen_low;
        timeout = en && !lock_ok && (wcnt == WW'(LOCK_MAX - 1));
    end

    // Window counter and lost-lock flag, both cleared outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || lock_ok || timeout) begin
            wcnt     <= '0;
            seen_low <= 1'b0;
        end else begin
            wcnt     <= wcnt + WW'(1);
            seen_low <= seen_low | ~pll_locked;
        end
    end

    AST_WD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt < WW'(LOCK_MAX)); // R8
endmodule

// File: rtl/vf_sequencer.sv
// Operating-point transition sequencer, top level. It takes requests from the
// held-request register and orders the voltage and ratio changes by
// direction. It stalls the core and blocks the bus during relock, and
// reports busy, done and relock timeout. Assumes the regulator follows the
// voltage-ID output and the PLL drops lock after a ratio change.
module vf_sequencer
    import vfs_pkg::*;
#(
    parameter int          VW        = 6,
    parameter int          RW        = 5,
    parameter int          DW        = 8,
    parameter int          LOCK_MAX  = 2500,
    parameter logic [5:0]  DEF_VCODE = 6'd20,
    parameter logic [4:0]  DEF_RATIO = 5'd8,
    localparam int         SW        = $clog2(LOCK_MAX + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vcode,
    input  logic [RW-1:0] req_ratio,
    input  logic [DW-1:0] dwell,
    input  logic          pll_locked,
    output logic [VW-1:0] vid_out,
    output logic [RW-1:0] ratio_out,
    output logic          core_stall,
    output logic          bus_block,
    output logic          busy,
    output logic          done,
    output logic          lock_err
);
    vfs_state_e    state;
    logic [VW-1:0] cur_v, tgt_v, pend_v;
    logic [RW-1:0] cur_r, tgt_r, pend_r;
    logic          pend_valid, take;
    logic          step_en, at_tgt, step_up, step_dn;
    logic          relock_en, lock_ok, timeout;
    logic          done_q, err_q;

    // A pending request is taken only between transitions.
    always_comb take = (state == ST_IDLE) && pend_valid;

    vfs_pending #(.VW(VW), .RW(RW)) u_pending (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_vcode(req_vcode), .req_ratio(req_ratio), .take(take),
        .pend_valid(pend_valid), .pend_vcode(pend_v), .pend_ratio(pend_r)
    );

    // Voltage steps are allowed only in the two stepping phases.
    always_comb step_en = (state == ST_VPRE) || (state == ST_VPOST);

    vfs_vstep #(.VW(VW), .DW(DW)) u_vstep (
        .clk(clk), .rst_n(rst_n), .en(step_en), .cur_vcode(cur_v),
        .tgt_vcode(tgt_v), .dwell(dwell), .at_tgt(at_tgt),
        .step_up(step_up), .step_dn(step_dn)
    );

    // The relock monitor runs only during the stall window.
    always_comb relock_en = (state == ST_RELOCK);

    vfs_relock #(.LOCK_MAX(LOCK_MAX)) u_relock (
        .clk(clk), .rst_n(rst_n), .en(relock_en), .pll_locked(pll_locked),
        .lock_ok(lock_ok), .timeout(timeout)
    );

    // Phase sequencing, ratio register, target capture and report pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_r  <= RW'(DEF_RATIO);
            tgt_v  <= VW'(DEF_VCODE);
            tgt_r  <= RW'(DEF_RATIO);
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        tgt_v <= pend_v;
                        tgt_r <= pend_r;
                        if (pend_v == cur_v && pend_r == cur_r) begin
                            done_q <= 1'b1;
                        end else if (pend_r > cur_r) begin
                            state <= ST_VPRE;
                        end else if (pend_r < cur_r) begin
                            state <= ST_RELOCK;
                            cur_r <= pend_r;
                        end else begin
                            state <= ST_VPOST;
                        end
                    end
                end
                ST_VPRE: begin
                    if (at_tgt) begin
                        state <= ST_RELOCK;
                        cur_r <= tgt_r;
                    end
                end
                ST_RELOCK: begin
                    if (lock_ok || timeout) state <= ST_VPOST;
                    if (timeout)            err_q <= 1'b1;
                end
                ST_VPOST: begin
                    if (at_tgt) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Voltage-code register, moved only by single-LSB stepper pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_v <= VW'(DEF_VCODE);
        else if (step_up) cur_v <= cur_v + VW'(1);
        else if (step_dn) cur_v <= cur_v - VW'(1);
    end

    // Output drive from the state and the point registers.
    always_comb begin
        vid_out    = cur_v;
        ratio_out  = cur_r;
        core_stall = (state == ST_RELOCK);
        bus_block  = (state == ST_RELOCK);
        busy       = (state != ST_IDLE);
        done       = done_q;
        lock_err   = err_q;
    end

    // Length of the current stall run, kept for the bound check.
    logic [SW-1:0] stall_run;
    always_ff @(posedge clk) begin
        if (!rst_n || !core_stall) stall_run <= '0;
        else                       stall_run <= stall_run + SW'(1);
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (vid_out == VW'(DEF_VCODE) && ratio_out == RW'(DEF_RATIO)
                    && !busy && !core_stall && !done && !lock_err)); // R1
    AST_UP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_out > $past(ratio_out)) |-> (vid_out == tgt_v)); // R2
    AST_UP_VOLT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_out != $past(vid_out) && $past(state) == ST_VPRE) |-> (ratio_out < tgt_r)); // R2
    AST_DOWN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_out != $past(vid_out)) |-> ($past(state) != ST_RELOCK && $past(state) != ST_IDLE)); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_out != $past(vid_out)) |->
            (vid_out == $past(vid_out) + VW'(1) || vid_out == $past(vid_out) - VW'(1))); // R4
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> (tgt_v == $past(tgt_v) && tgt_r == $past(tgt_r))); // R6
    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> (stall_run < SW'(LOCK_MAX))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> ($past(core_stall) && !core_stall)); // R12
endmodule

// File: tb/vf_sequencer_test.sv
// Bench: behavioural reference model compared at every falling edge, plus
// directed ordering, dwell, deferral and timeout checks.
module vf_sequencer_test;
    localparam int VW = 6, RW = 5, DW = 8, LOCK_MAX = 2500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vcode = '0;
    logic [RW-1:0] req_ratio = '0;
    logic [DW-1:0] dwell = 8'd3;
    logic          pll_locked = 1'b1;
    logic [VW-1:0] vid_out;
    logic [RW-1:0] ratio_out;
    logic          core_stall, bus_block, busy, done, lock_err;

    vf_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vcode(req_vcode),
        .req_ratio(req_ratio), .dwell(dwell), .pll_locked(pll_locked),
        .vid_out(vid_out), .ratio_out(ratio_out), .core_stall(core_stall),
        .bus_block(bus_block), .busy(busy), .done(done), .lock_err(lock_err)
    );

    always #2 clk = ~clk;

    int vectors = 0, fails = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // PLL model: drops lock when the ratio changes, relocks after pll_lat cycles.
    int pll_lat = 4;
    bit pll_hang = 0;
    int pll_cnt = 0;
    int pll_last = 8;
    always @(negedge clk) begin
        if (!rst_n) begin
            pll_locked <= 1'b1; pll_last = ratio_out; pll_cnt = 0;
        end else if (int'(ratio_out) != pll_last) begin
            pll_last = ratio_out; pll_locked <= 1'b0; pll_cnt = pll_lat;
        end else if (pll_hang) begin
            pll_locked <= 1'b0;
        end else begin
            if (pll_cnt > 0) pll_cnt--;
            if (pll_cnt == 0) pll_locked <= 1'b1;
        end
    end

    // Reference model: phase 0 idle, 1 voltage-first, 2 relock, 3 voltage-after.
    int ms, mv, mr, tv, tr, dc, wc, pvv, pvr;
    bit sl, pv, mdone, merr;
    always @(posedge clk) begin
        int n_ms, n_mv, n_mr, n_tv, n_tr, n_dc, n_wc, n_pvv, n_pvr;
        bit n_sl, n_pv, n_done, n_err, tk;
        if (!rst_n) begin
            ms = 0; mv = 20; mr = 8; tv = 20; tr = 8; dc = 0; wc = 0;
            pvv = 0; pvr = 0; sl = 0; pv = 0; mdone = 0; merr = 0;
        end else begin
            n_ms = ms; n_mv = mv; n_mr = mr; n_tv = tv; n_tr = tr; n_dc = dc;
            n_wc = wc; n_sl = sl; n_pvv = pvv; n_pvr = pvr; n_done = 0; n_err = 0;
            tk = (ms == 0) && pv;
            n_pv = req_valid || (pv && !tk);
            if (req_valid) begin n_pvv = req_vcode; n_pvr = req_ratio; end
            case (ms)
                0: if (pv) begin
                    n_tv = pvv; n_tr = pvr;
                    if (pvv == mv && pvr == mr) n_done = 1;
                    else if (pvr > mr) n_ms = 1;
                    else if (pvr < mr) begin n_ms = 2; n_mr = pvr; end
                    else n_ms = 3;
                end
                1, 3: begin
                    if (mv == tv) begin
                        n_dc = 0;
                        if (ms == 1) begin n_ms = 2; n_mr = tr; end
                        else begin n_ms = 0; n_done = 1; end
                    end else if (dc == int'(dwell)) begin
                        n_mv = (tv > mv) ? mv + 1 : mv - 1; n_dc = 0;
                    end else n_dc = dc + 1;
                end
                default: begin
                    if (pll_locked && sl) begin
                        n_ms = 3; n_wc = 0; n_sl = 0;
                    end else if (wc == LOCK_MAX - 1) begin
                        n_ms = 3; n_wc = 0; n_sl = 0; n_err = 1;
                    end else begin
                        n_wc = wc + 1; if (!pll_locked) n_sl = 1;
                    end
                end
            endcase
            ms = n_ms; mv = n_mv; mr = n_mr; tv = n_tv; tr = n_tr; dc = n_dc;
            wc = n_wc; sl = n_sl; pv = n_pv; pvv = n_pvv; pvr = n_pvr;
            mdone = n_done; merr = n_err;
        end
    end

    // Monitor: per-cycle comparison plus ordering, dwell and stall checks.
    int prev_v = 20, prev_r = 8, start_r = 8, last_step = -1;
    int done_cnt = 0, stall_len = 0, max_stall = 0;
    bit prev_busy = 0, err_seen = 0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(int'(vid_out) == mv, "R4 vid_out", vid_out, mv);
            chk(int'(ratio_out) == mr, "R2 ratio_out", ratio_out, mr);
            chk(busy == (ms != 0), "R11 busy", busy, ms != 0);
            chk(core_stall == (ms == 2), "R8 core_stall", core_stall, ms == 2);
            chk(bus_block == core_stall, "R9 bus_block", bus_block, core_stall);
            chk(done == mdone, "R11 done", done, mdone);
            chk(lock_err == merr, "R12 lock_err", lock_err, merr);
            if (busy && !prev_busy) begin start_r = prev_r; last_step = -1; end
            if (int'(ratio_out) > prev_r)
                chk(int'(vid_out) == tv, "R2 voltage at target before ratio rise", vid_out, tv);
            if (int'(vid_out) != prev_v && busy) begin
                if (tr < start_r)
                    chk(int'(ratio_out) == tr, "R3 ratio lowered before voltage", ratio_out, tr);
                if (tr > start_r)
                    chk(int'(ratio_out) == start_r, "R2 ratio held while voltage rises", ratio_out, start_r);
                if (last_step >= 0)
                    chk(cycles - last_step == int'(dwell) + 1, "R5 dwell spacing",
                        cycles - last_step, int'(dwell) + 1);
                last_step = cycles;
            end
            if (done) done_cnt++;
            if (lock_err) err_seen = 1;
            if (core_stall) begin
                stall_len++;
                if (stall_len > max_stall) max_stall = stall_len;
            end else stall_len = 0;
        end
        prev_v = vid_out; prev_r = ratio_out; prev_busy = busy;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            finish_up();
        end
    end

    task automatic req(input int v, input int r);
        @(negedge clk);
        req_valid = 1'b1; req_vcode = VW'(v); req_ratio = RW'(r);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        while (ms != 0 || pv) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk(vid_out == 6'd20 && ratio_out == 5'd8, "R1 reset point", vid_out, 20);
        chk(!busy && !core_stall && !bus_block && !done && !lock_err, "R1 idle flags", busy, 0);
        rst_n = 1'b1;

        // R2: ratio and voltage both rise.
        req(24, 12); settle();
        chk(vid_out == 6'd24 && ratio_out == 5'd12, "R2 final point", vid_out, 24);

        // R3: ratio and voltage both fall.
        pll_lat = 7;
        req(18, 6); settle();
        chk(vid_out == 6'd18 && ratio_out == 5'd6, "R3 final point", vid_out, 18);

        // R10: request equal to the current point.
        req(18, 6);
        @(negedge clk);
        chk(done && !busy && !core_stall, "R10 immediate done", done, 1);

        // Voltage-only change with no relock, and no dwell.
        dwell = 8'd0;
        req(21, 6); settle();
        chk(vid_out == 6'd21 && max_stall < 12, "R4 voltage-only point", vid_out, 21);

        // R6 and R7: requests while busy; only the newest is started.
        dwell = 8'd2;
        done_cnt = 0;
        req(26, 14);
        req(22, 10);
        req(19, 9);
        settle();
        chk(vid_out == 6'd19 && ratio_out == 5'd9, "R7 newest pending applied", vid_out, 19);
        chk(done_cnt == 2, "R6 deferred transitions completed", done_cnt, 2);

        // R8 and R12: the PLL never relocks.
        max_stall = 0;
        pll_hang = 1;
        req(23, 11); settle();
        pll_hang = 0;
        chk(err_seen, "R12 timeout flagged", err_seen, 1);
        chk(max_stall == LOCK_MAX, "R8 stall bounded", max_stall, LOCK_MAX);
        chk(vid_out == 6'd23 && ratio_out == 5'd11, "R12 transition continued", vid_out, 23);

        // R1: reset in the middle of a transition.
        req(28, 15);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(vid_out == 6'd20 && ratio_out == 5'd8 && !busy, "R1 reset mid-transition", vid_out, 20);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule